// File: doc/BRIEF.md
# Float-to-Integer Converter with Selectable Rounding

This block turns a single-precision binary floating-point word (1 sign bit, 8 exponent bits, 23 fraction bits) into a signed 32-bit two's-complement integer. A 3-bit code chosen for each input selects the rounding rule. The rules are chopping toward zero, rounding up toward plus infinity, rounding down toward minus infinity, nearest with ties away from zero, and nearest with ties to the even integer. Inputs that have no integer image raise a single error flag and give a defined saturated word: NaN, the infinities, and magnitudes outside the signed 32-bit range.

The converter has two register stages and no back-pressure. The first stage splits the input into fields and lines the significand up on the integer boundary. It keeps the integer magnitude, one guard bit (the first bit below the binary point) and one sticky bit (the OR of all lower bits). The second stage adds the rounding increment, applies the sign and saturates. One word can enter on every clock cycle. Each result appears with its valid strobe a fixed two cycles after the input strobe.

Top module: `f2i_convert`

## Requirements
- R1: Mode code 0 chops toward zero (7.5 gives 7, -7.5 gives -7). The unused codes 5, 6 and 7 behave exactly like code 0.
- R2: Mode code 1 rounds toward plus infinity (10.5 gives 11, -7.5 gives -7, -11.25 gives -11).
- R3: Mode code 2 rounds toward minus infinity (10.75 gives 10, -7.5 gives -8, -11.25 gives -12).
- R4: Mode code 3 rounds to nearest, and a value exactly halfway goes away from zero (7.5 gives 8, 8.5 gives 9, -8.5 gives -9, 0.5 gives 1).
- R5: Mode code 4 rounds to nearest, and a value exactly halfway goes to the even integer (8.5 gives 8, 7.5 gives 8, 2.5 gives 2, -8.5 gives -8, -0.5 gives 0).
- R6: Any NaN (exponent field all ones, fraction non-zero) gives 0x8000_0000 with out_invalid set, in every mode.
- R7: Infinities and values whose rounded result lies outside [-2^31, 2^31-1] give 0x7FFF_FFFF (positive) or 0x8000_0000 (negative) with out_invalid set. Exactly -2^31 gives 0x8000_0000 with the flag clear, and 2^31-128 converts exactly.
- R8: Zero of either sign gives 0 in every mode. A subnormal gives 0 in every mode, with two exceptions: a positive one gives 1 under mode 1, and a negative one gives -1 (0xFFFF_FFFF) under mode 2.
- R9: out_valid is high exactly in the cycle two clock edges after the edge that samples in_valid high. Back-to-back inputs give back-to-back results in order.
- R10: While rst_n is low, and after reset until the first result arrives, out_valid, out_invalid and out_result are all zero.
- R11: out_invalid is low for every in-range result and whenever out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word present this cycle |
| in_data | input | 32 | Single-precision input word |
| in_mode | input | 3 | Rounding rule code (0 to 4, others act as 0) |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 32 | Signed two's-complement result |
| out_invalid | output | 1 | NaN, infinity or out-of-range input |

## Verification
A wrong guard or sticky bit from the alignment stage changes the rounded value by exactly one. This shows on out_result two cycles after the input, and only for the modes and tie patterns that read that bit. For this reason the sweep crosses every exponent near the integer boundary with fractions that are exact, just below half, exactly half and just above half, under all eight mode codes and both signs. A misclassified special or range limit shows as a wrong saturation word or a wrong flag on the same result. A pipeline slip shows as out_valid one cycle early or late at the very next strobe.

// File: rtl/f2i_pkg.sv
`timescale 1ns/1ps
package f2i_pkg;

  // Rounding rule after decoding the 3-bit mode code.
  typedef enum logic [2:0] {
    RM_TRUNC = 3'd0,
    RM_CEIL  = 3'd1,
    RM_FLOOR = 3'd2,
    RM_AWAY  = 3'd3,
    RM_EVEN  = 3'd4
  } rmode_e;

  // Class of the input after the alignment stage.
  typedef enum logic [1:0] {
    K_NUM = 2'd0,
    K_NAN = 2'd1,
    K_OVF = 2'd2
  } kind_e;

  // Unused codes fall back to chopping.
  function automatic rmode_e decode_mode(input logic [2:0] code);
    case (code)
      3'd1:    return RM_CEIL;
      3'd2:    return RM_FLOOR;
      3'd3:    return RM_AWAY;
      3'd4:    return RM_EVEN;
      default: return RM_TRUNC;
    endcase
  endfunction

  // Decide +1 on the magnitude from the sign, the integer lsb, guard and sticky.
  function automatic logic round_up(input rmode_e m, input logic neg,
                                    input logic lsb, input logic g,
                                    input logic st);
    logic inexact;
    inexact = g | st;
    case (m)
      RM_CEIL:  return !neg && inexact;
      RM_FLOOR: return neg && inexact;
      RM_AWAY:  return g;
      RM_EVEN:  return g && (st || lsb);
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/f2i_align.sv
`timescale 1ns/1ps
module f2i_align
  import f2i_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32
) (
  input  logic [EXP_W+MAN_W:0] fp,
  output logic                 sign,
  output logic [INT_W-1:0]     mag,
  output logic                 guard,
  output logic                 sticky,
  output kind_e                kind
);
  localparam int FP_W  = 1 + EXP_W + MAN_W;
  localparam int SIG_W = MAN_W + 1;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int ALN_W = INT_W + SIG_W;
  localparam int SA_W  = $clog2(INT_W);
  localparam int UE_W  = EXP_W + 2;
  localparam logic signed [UE_W-1:0] BIAS_S = UE_W'(BIAS);
  localparam logic signed [UE_W-1:0] UE_M1  = -1;
  localparam logic signed [UE_W-1:0] UE_TOP = UE_W'(INT_W - 1);

  logic [EXP_W-1:0]       exp_f;
  logic [MAN_W-1:0]       frac_f;
  logic                   exp_max, exp_zero;
  logic [SIG_W-1:0]       sig;
  logic signed [UE_W-1:0] ue;
  logic [SA_W-1:0]        sa;
  logic [ALN_W-1:0]       wide;

  assign sign     = fp[FP_W-1];
  assign exp_f    = fp[FP_W-2:MAN_W];
  assign frac_f   = fp[MAN_W-1:0];
  assign exp_max  = &exp_f;
  assign exp_zero = (exp_f == '0);
  assign sig      = {~exp_zero, frac_f};
  assign ue       = signed'({2'b00, exp_f}) - BIAS_S;
  assign sa       = SA_W'(ue + UE_W'(1));
  // Shift by (ue+1): binary point then sits just above bit MAN_W.
  assign wide     = {{INT_W{1'b0}}, sig} << sa;

  always_comb begin
    kind   = K_NUM;
    mag    = '0;
    guard  = 1'b0;
    sticky = 1'b0;
    if (exp_max) begin
      kind = (frac_f != '0) ? K_NAN : K_OVF;
    end else if (ue >= UE_TOP) begin
      if (sign && (frac_f == '0) && (ue == UE_TOP))
        mag = {1'b1, {(INT_W-1){1'b0}}};
      else
        kind = K_OVF;
    end else if (ue < UE_M1) begin
      sticky = |sig;
    end else begin
      mag    = wide[ALN_W-1 -: INT_W];
      guard  = wide[MAN_W];
      sticky = |wide[MAN_W-1:0];
    end
  end
endmodule

// File: rtl/f2i_round.sv
`timescale 1ns/1ps
module f2i_round
  import f2i_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  rmode_e           mode,
  input  logic             sign,
  input  logic [INT_W-1:0] mag,
  input  logic             guard,
  input  logic             sticky,
  input  kind_e            kind,
  output logic [INT_W-1:0] result,
  output logic             invalid,
  output logic             inc
);
  localparam logic [INT_W-1:0] POS_MAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] NEG_MIN = {1'b1, {(INT_W-1){1'b0}}};

  logic [INT_W:0] mag_r;
  logic           rng_bad;

  assign inc     = round_up(mode, sign, mag[0], guard, sticky);
  assign mag_r   = {1'b0, mag} + (INT_W+1)'(inc);
  assign rng_bad = sign ? (mag_r > {1'b0, NEG_MIN}) : (mag_r > {1'b0, POS_MAX});

  always_comb begin
    result  = '0;
    invalid = 1'b0;
    case (kind)
      K_NAN: begin
        result  = NEG_MIN;
        invalid = 1'b1;
      end
      K_OVF: begin
        result  = sign ? NEG_MIN : POS_MAX;
        invalid = 1'b1;
      end
      default: begin
        if (rng_bad) begin
          result  = sign ? NEG_MIN : POS_MAX;
          invalid = 1'b1;
        end else begin
          result = sign ? (~mag_r[INT_W-1:0] + INT_W'(1)) : mag_r[INT_W-1:0];
        end
      end
    endcase
  end
endmodule

// File: rtl/f2i_convert.sv
`timescale 1ns/1ps
module f2i_convert
  import f2i_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [EXP_W+MAN_W:0] in_data,
  input  logic [2:0]           in_mode,
  output logic                 out_valid,
  output logic [INT_W-1:0]     out_result,
  output logic                 out_invalid
);
  // Stage 0: combinational alignment
  logic             a_sign, a_guard, a_sticky;
  logic [INT_W-1:0] a_mag;
  kind_e            a_kind;

  f2i_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_align (
    .fp     (in_data),
    .sign   (a_sign),
    .mag    (a_mag),
    .guard  (a_guard),
    .sticky (a_sticky),
    .kind   (a_kind)
  );

  // Stage 1 registers
  logic             s1_valid, s1_sign, s1_guard, s1_sticky;
  logic [INT_W-1:0] s1_mag;
  kind_e            s1_kind;
  rmode_e           s1_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_sign   <= 1'b0;
      s1_guard  <= 1'b0;
      s1_sticky <= 1'b0;
      s1_mag    <= '0;
      s1_kind   <= K_NUM;
      s1_mode   <= RM_TRUNC;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_sign   <= a_sign;
        s1_guard  <= a_guard;
        s1_sticky <= a_sticky;
        s1_mag    <= a_mag;
        s1_kind   <= a_kind;
        s1_mode   <= decode_mode(in_mode);
      end
    end
  end

  // Stage 1 combinational: round and saturate
  logic [INT_W-1:0] r_result;
  logic             r_invalid;
  logic             rnd_inc;

  f2i_round #(.INT_W(INT_W)) u_round (
    .mode    (s1_mode),
    .sign    (s1_sign),
    .mag     (s1_mag),
    .guard   (s1_guard),
    .sticky  (s1_sticky),
    .kind    (s1_kind),
    .result  (r_result),
    .invalid (r_invalid),
    .inc     (rnd_inc)
  );

  // Stage 2 registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
    end else begin
      out_valid   <= s1_valid;
      out_invalid <= s1_valid & r_invalid;
      if (s1_valid) out_result <= r_result;
    end
  end
endmodule

// File: rtl/f2i_checker.sv
`timescale 1ns/1ps
module f2i_checker
  import f2i_pkg::*;
#(
  parameter int INT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             s1_valid,
  input rmode_e           s1_mode,
  input kind_e            s1_kind,
  input logic             s1_guard,
  input logic             s1_sticky,
  input logic             s1_mag_lsb,
  input logic             rnd_inc,
  input logic             out_valid,
  input logic [INT_W-1:0] out_result,
  input logic             out_invalid
);
  localparam logic [INT_W-1:0] POS_MAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] NEG_MIN = {1'b1, {(INT_W-1){1'b0}}};

  logic [1:0] vhist;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vhist <= 2'b00;
    else        vhist <= {vhist[0], in_valid};
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vhist[1]); // R9

  AST_NAN_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_kind == K_NAN) |=> (out_valid && out_invalid && out_result == NEG_MIN)); // R6

  AST_SAT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    out_invalid |-> (out_valid && (out_result == NEG_MIN || out_result == POS_MAX))); // R7

  AST_TRUNC_NO_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_mode == RM_TRUNC) |-> !rnd_inc); // R1

  AST_INC_NEEDS_FRACTION: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && rnd_inc) |-> (s1_guard || s1_sticky)); // R2

  AST_EVEN_TIE: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_kind == K_NUM && s1_mode == RM_EVEN && s1_guard && !s1_sticky)
      |-> (rnd_inc == s1_mag_lsb)); // R5

  AST_FLAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_invalid); // R11
endmodule

bind f2i_convert f2i_checker #(.INT_W(INT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .s1_valid    (s1_valid),
  .s1_mode     (s1_mode),
  .s1_kind     (s1_kind),
  .s1_guard    (s1_guard),
  .s1_sticky   (s1_sticky),
  .s1_mag_lsb  (s1_mag[0]),
  .rnd_inc     (rnd_inc),
  .out_valid   (out_valid),
  .out_result  (out_result),
  .out_invalid (out_invalid)
);

// File: tb/sim_f2i_convert.sv
`timescale 1ns/1ps
module sim_f2i_convert;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_data;
  logic [2:0]  in_mode;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_invalid;

  always #2.5 clk = ~clk;

  f2i_convert u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_mode(in_mode), .out_valid(out_valid), .out_result(out_result),
    .out_invalid(out_invalid)
  );

  int n_chk = 0;
  int n_fail = 0;
  int nin = 0;
  int nout = 0;
  logic [31:0] e_res [0:8191];
  logic        e_flg [0:8191];
  logic [31:0] e_in  [0:8191];
  string       e_tag [0:8191];

  // Reference by integer division and remainder, independent of the shifter.
  function automatic logic [32:0] ref_conv(input logic [31:0] x, input logic [2:0] md);
    logic s, inexact, up;
    int ex, sh;
    longint fr, sig, q, r, half, mag;
    s  = x[31];
    ex = int'(x[30:23]);
    fr = longint'(x[22:0]);
    if (ex == 255) begin
      if (fr != 0) return {1'b1, 32'h8000_0000};
      return {1'b1, s ? 32'h8000_0000 : 32'h7FFF_FFFF};
    end
    if (ex >= 170) return {1'b1, s ? 32'h8000_0000 : 32'h7FFF_FFFF};
    sig = (ex == 0) ? fr : (fr + 64'sd8388608);
    sh  = 150 - ((ex == 0) ? 1 : ex);
    if (sh <= 0) begin
      q = sig * (64'sd1 << (-sh)); r = 0; half = 1;
    end else if (sh > 40) begin
      q = 0; r = (sig != 0) ? 1 : 0; half = 2;
    end else begin
      q = sig / (64'sd1 << sh); r = sig % (64'sd1 << sh); half = 64'sd1 << (sh - 1);
    end
    inexact = (r != 0);
    case (md)
      3'd1:    up = !s && inexact;
      3'd2:    up = s && inexact;
      3'd3:    up = (r >= half);
      3'd4:    up = (r > half) || ((r == half) && q[0]);
      default: up = 1'b0;
    endcase
    mag = q + (up ? 64'sd1 : 64'sd0);
    if (!s && mag > 64'sd2147483647) return {1'b1, 32'h7FFF_FFFF};
    if (s && mag > 64'sd2147483648) return {1'b1, 32'h8000_0000};
    return {1'b0, s ? 32'(-mag) : 32'(mag)};
  endfunction

  function automatic string tag_of(input logic [31:0] x, input logic [2:0] md, input logic flg);
    if (x[30:23] == 8'hFF && x[22:0] != 0) return "R6";
    if (flg) return "R7";
    if (x[30:23] < 8'd100) return "R8";
    case (md)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R1";
    endcase
  endfunction

  task automatic drive(input logic [31:0] x, input logic [2:0] md);
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = x; in_mode = md;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic push_exp(input logic [31:0] x, input logic [2:0] md,
                          input logic [31:0] r, input logic f, input string tg);
    e_in[nin] = x; e_res[nin] = r; e_flg[nin] = f; e_tag[nin] = tg;
    nin++;
    drive(x, md);
  endtask

  task automatic push_ref(input logic [31:0] x, input logic [2:0] md);
    logic [32:0] v;
    v = ref_conv(x, md);
    push_exp(x, md, v[31:0], v[32], tag_of(x, md, v[32]));
  endtask

  task automatic chk(input bit ok, input string tg, input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tg, act, exp_v);
    end
  endtask

  // Output monitor, sampled on the falling edge.
  bit vh0, vh1, exp_v;
  always @(negedge clk) begin
    if (!rst_n) begin
      vh0 = 1'b0; vh1 = 1'b0;
    end else begin
      exp_v = vh1; vh1 = vh0; vh0 = in_valid;
      chk(out_valid === exp_v, "R9 valid timing", {31'd0, out_valid}, {31'd0, exp_v});
      if (!out_valid)
        chk(out_invalid === 1'b0, "R11 flag without valid", {31'd0, out_invalid}, 32'd0);
      if (out_valid && nout < nin) begin
        chk(out_result === e_res[nout], e_tag[nout], out_result, e_res[nout]);
        chk(out_invalid === e_flg[nout], {e_tag[nout], " flag"}, {31'd0, out_invalid},
            {31'd0, e_flg[nout]});
        nout++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d results", nout, nin);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [22:0] fr_l [0:5];
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_mode = '0;
    @(negedge clk);
    chk(out_valid === 1'b0 && out_invalid === 1'b0 && out_result === 32'd0,
        "R10 in reset", out_result, 32'd0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0 && out_invalid === 1'b0 && out_result === 32'd0,
        "R10 after reset", out_result, 32'd0);

    // Directed values with hand-computed answers
    push_exp(32'h40F00000, 3'd0, 32'd7, 1'b0, "R1");
    push_exp(32'hC0F00000, 3'd0, -32'sd7, 1'b0, "R1");
    push_exp(32'h40F00000, 3'd5, 32'd7, 1'b0, "R1");
    push_exp(32'hC0F00000, 3'd6, -32'sd7, 1'b0, "R1");
    push_exp(32'h41280000, 3'd7, 32'd10, 1'b0, "R1");
    push_exp(32'h41280000, 3'd1, 32'd11, 1'b0, "R2");
    push_exp(32'hC0F00000, 3'd1, -32'sd7, 1'b0, "R2");
    push_exp(32'hC1340000, 3'd1, -32'sd11, 1'b0, "R2");
    push_exp(32'h412C0000, 3'd2, 32'd10, 1'b0, "R3");
    push_exp(32'hC0F00000, 3'd2, -32'sd8, 1'b0, "R3");
    push_exp(32'hC1340000, 3'd2, -32'sd12, 1'b0, "R3");
    push_exp(32'h40F00000, 3'd3, 32'd8, 1'b0, "R4");
    push_exp(32'h41080000, 3'd3, 32'd9, 1'b0, "R4");
    push_exp(32'hC1080000, 3'd3, -32'sd9, 1'b0, "R4");
    push_exp(32'h3F000000, 3'd3, 32'd1, 1'b0, "R4");
    push_exp(32'h41080000, 3'd4, 32'd8, 1'b0, "R5");
    push_exp(32'h40F00000, 3'd4, 32'd8, 1'b0, "R5");
    push_exp(32'h40200000, 3'd4, 32'd2, 1'b0, "R5");
    push_exp(32'h3FC00000, 3'd4, 32'd2, 1'b0, "R5");
    push_exp(32'hC1080000, 3'd4, -32'sd8, 1'b0, "R5");
    push_exp(32'hBF000000, 3'd4, 32'd0, 1'b0, "R5");
    push_exp(32'h7FC00000, 3'd0, 32'h8000_0000, 1'b1, "R6");
    push_exp(32'hFF800001, 3'd3, 32'h8000_0000, 1'b1, "R6");
    push_exp(32'h7F800000, 3'd1, 32'h7FFF_FFFF, 1'b1, "R7");
    push_exp(32'hFF800000, 3'd2, 32'h8000_0000, 1'b1, "R7");
    push_exp(32'h4F000000, 3'd0, 32'h7FFF_FFFF, 1'b1, "R7");
    push_exp(32'hCF000000, 3'd2, 32'h8000_0000, 1'b0, "R7");
    push_exp(32'hCF000001, 3'd0, 32'h8000_0000, 1'b1, "R7");
    push_exp(32'h4EFFFFFF, 3'd4, 32'h7FFF_FF80, 1'b0, "R7");
    push_exp(32'h00000000, 3'd1, 32'd0, 1'b0, "R8");
    push_exp(32'h80000000, 3'd2, 32'd0, 1'b0, "R8");
    push_exp(32'h00000001, 3'd1, 32'd1, 1'b0, "R8");
    push_exp(32'h00000001, 3'd2, 32'd0, 1'b0, "R8");
    push_exp(32'h80000001, 3'd2, 32'hFFFF_FFFF, 1'b0, "R8");
    push_exp(32'h80000001, 3'd1, 32'd0, 1'b0, "R8");
    push_exp(32'h807FFFFF, 3'd3, 32'd0, 1'b0, "R8");
    idle(); idle(); idle();

    // Sweep: all mode codes, both signs, exponents around the integer range
    fr_l[0] = 23'h000000; fr_l[1] = 23'h000001; fr_l[2] = 23'h400000;
    fr_l[3] = 23'h3FFFFF; fr_l[4] = 23'h7FFFFF; fr_l[5] = 23'h200001;
    for (int md = 0; md < 8; md++)
      for (int sg = 0; sg < 2; sg++)
        for (int ex = 100; ex <= 160; ex++)
          for (int k = 0; k < 6; k++) begin
            logic [22:0] fr;
            fr = (k == 5) ? 23'((ex * 2654435 + md * 977) ^ 32'h155555) : fr_l[k];
            push_ref({sg[0], 8'(ex), fr}, 3'(md));
            if ((nin % 7) == 3) idle();
          end
    idle();
    repeat (6) idle();
    chk(nout == nin, "R9 result count", 32'(nout), 32'(nin));
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule